// File: doc/BRIEF.md
# Atomic-Alias Accumulator Register with Sniff Adder

This block is a small peripheral register slice holding one 32-bit accumulator and a control register. Software and DMA reach both registers through four address aliases of the same 4 KB window. Address bits 13:12 choose what a write does: a plain overwrite, an XOR of the written value into the register, a bit-set using the value as a mask, or a bit-clear using the value as a mask. Reads return the register contents whichever alias is used.

The accumulator can also watch a data stream moving past it. When the control register enables sniffing in add mode, each word presented with a valid strobe is added to the accumulator modulo 2^32, optionally byte-reversed first. With plain memory copies alone, a DMA engine can then form OR, AND, XOR, NOT and ADD; sniffing the accumulator's own value doubles it, which scales a table index by two.

Top module: `sniffAccReg`

## Requirements
- R1: After reset both the control register (word offset 0x0) and the accumulator (word offset 0x4) read as zero.
- R2: A write at alias 0 (address bits 13:12 = 0) replaces the addressed register with the written value; a read returns the current value.
- R3: A write at alias 1 (bits 13:12 = 1, offset 0x1000) XORs the written value into the addressed register.
- R4: A write at alias 2 (bits 13:12 = 2, offset 0x2000) sets every bit that is 1 in the written value.
- R5: A write at alias 3 (bits 13:12 = 3, offset 0x3000) clears every bit that is 1 in the written value.
- R6: A read at any of the four aliases returns the same register value.
- R7: With the enable (control bit 0) set and the mode field (control bits 8:5) equal to 0xF, each sniff word with the valid strobe high is added to the accumulator modulo 2^32 one cycle later; adding the accumulator's own value doubles it.
- R8: When the swap input is high with a sniff word, the word is byte-reversed before the add, so its bits 31:24 land in bits 7:0.
- R9: A sniff word leaves the accumulator unchanged when the enable is 0 or the mode field is not 0xF.
- R10: A write and a sniff add in the same cycle are combined with the write applied first and the add second.
- R11: The control register stores only bit 0 and bits 8:5; all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 14 | Byte address; bits 13:12 select the alias, bits 11:0 the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register (combinational) |
| sniffValid | input | 1 | Sniff word valid |
| sniffData | input | 32 | Sniffed data word |
| sniffSwap | input | 1 | Byte-reverse the sniffed word before adding |

## Verification
The adder is driven with a sum that wraps past 2^32, with the accumulator's own value to show doubling, and with a byte-reversed word whose only nonzero byte moves from the top to the bottom, which separates swapped from unswapped paths. Sniff words are also offered with the enable off and with a non-add mode, where any change to the accumulator is a failure. The four aliases are each written with a mask whose result differs from the other three operations, and a same-cycle XOR write plus add is chosen so that write-then-add and add-then-write give different values.

// File: rtl/sniffAccPkg.sv
package sniffAccPkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_XOR   = 2'd1,
    ACC_SET   = 2'd2,
    ACC_CLR   = 2'd3
  } accessKind_e;

  typedef struct packed {
    logic        accWr;
    accessKind_e kind;
    logic        addEn;
    logic        swap;
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] applyAccess(
    input logic [WORD_W-1:0] oldVal,
    input logic [WORD_W-1:0] wrVal,
    input accessKind_e       kind
  );
    unique case (kind)
      ACC_PLAIN: applyAccess = wrVal;
      ACC_XOR:   applyAccess = oldVal ^ wrVal;
      ACC_SET:   applyAccess = oldVal | wrVal;
      default:   applyAccess = oldVal & ~wrVal;
    endcase
  endfunction
endpackage

// File: rtl/sniffAccCtrl.sv
module sniffAccCtrl
  import sniffAccPkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int ALIAS_LSB = 12,
  parameter int CTRL_WORD = 0,
  parameter int ACC_WORD  = 1,
  parameter int MODE_W    = 4,
  parameter int MODE_LSB  = 5,
  parameter logic [MODE_W-1:0] ADD_MODE = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sniffValid,
  input  logic              sniffSwap,
  output dpStrobe_t         strobe,
  output logic [WORD_W-1:0] ctrlImage,
  output logic              ctrlSel,
  output logic              accSel
);
  localparam int WSEL_W = ALIAS_LSB - 2;
  localparam logic [WORD_W-1:0] CTRL_MASK =
    WORD_W'(((1 << MODE_W) - 1) << MODE_LSB) | WORD_W'(1);

  logic [WSEL_W-1:0]  wordSel;
  logic               aligned;
  accessKind_e        kind;
  logic               ctrlWr;
  logic [WORD_W-1:0]  ctrlQ;
  logic               enableQ;
  logic [MODE_W-1:0]  modeQ;

  assign wordSel = addr[ALIAS_LSB-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign kind    = accessKind_e'(addr[ADDR_W-1:ALIAS_LSB]);
  assign ctrlSel = aligned && (wordSel == WSEL_W'(CTRL_WORD));
  assign accSel  = aligned && (wordSel == WSEL_W'(ACC_WORD));
  assign ctrlWr  = wrEn && ctrlSel;

  assign enableQ = ctrlQ[0];
  assign modeQ   = ctrlQ[MODE_LSB +: MODE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= applyAccess(ctrlQ, wrData, kind) & CTRL_MASK;
    end
  end

  assign ctrlImage = ctrlQ;

  always_comb begin
    strobe.accWr = wrEn && accSel;
    strobe.kind  = kind;
    strobe.addEn = sniffValid && enableQ && (modeQ == ADD_MODE);
    strobe.swap  = sniffSwap;
  end

  // R9
  sniff_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sniffValid && !ctrlImage[0]) |-> !strobe.addEn);

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.accWr, ctrlWr}));

  // R11
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> ((ctrlImage & ~CTRL_MASK) == '0));
endmodule

// File: rtl/sniffAccPath.sv
module sniffAccPath
  import sniffAccPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] sniffData,
  output logic [WORD_W-1:0] accQ
);
  localparam int NBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] reversed;
  logic [WORD_W-1:0] addend;
  logic [WORD_W-1:0] afterWrite;
  logic [WORD_W-1:0] accNext;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign reversed[b*BYTE_W +: BYTE_W] = sniffData[(NBYTES-1-b)*BYTE_W +: BYTE_W];
  end

  assign addend     = strobe.swap ? reversed : sniffData;
  assign afterWrite = strobe.accWr ? applyAccess(accQ, wrData, strobe.kind) : accQ;
  assign accNext    = strobe.addEn ? afterWrite + addend : afterWrite;

  always_ff @(posedge clk) begin
    if (!rstN) accQ <= '0;
    else       accQ <= accNext;
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.addEn && !strobe.accWr) |=> $stable(accQ));

  // R7
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addEn && !strobe.accWr && !strobe.swap) |=>
      accQ == $past(accQ) + $past(sniffData));

  // R10
  xor_then_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addEn && strobe.accWr && strobe.kind == ACC_XOR && !strobe.swap) |=>
      accQ == ($past(accQ) ^ $past(wrData)) + $past(sniffData));

  // R8
  swap_low_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addEn && !strobe.accWr && strobe.swap) |=>
      accQ[BYTE_W-1:0] == $past(accQ[BYTE_W-1:0]) + $past(sniffData[WORD_W-1 -: BYTE_W]));
endmodule

// File: rtl/sniffAccReg.sv
module sniffAccReg
  import sniffAccPkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int ALIAS_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  input  logic              sniffValid,
  input  logic [WORD_W-1:0] sniffData,
  input  logic              sniffSwap
);
  dpStrobe_t         strobe;
  logic [WORD_W-1:0] ctrlImage;
  logic [WORD_W-1:0] accQ;
  logic              ctrlSel;
  logic              accSel;

  sniffAccCtrl #(.ADDR_W(ADDR_W), .ALIAS_LSB(ALIAS_LSB)) uCtrl (
    .clk, .rstN, .wrEn, .addr, .wrData, .sniffValid, .sniffSwap,
    .strobe, .ctrlImage, .ctrlSel, .accSel
  );

  sniffAccPath uPath (
    .clk, .rstN, .strobe, .wrData, .sniffData, .accQ
  );

  always_comb begin
    if (ctrlSel)     rdData = ctrlImage;
    else if (accSel) rdData = accQ;
    else             rdData = '0;
  end
endmodule

// File: tb/sniffAccReg_test.sv
module sniffAccReg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sniffValid = 1'b0;
  logic [31:0] sniffData = '0;
  logic        sniffSwap = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  localparam logic [13:0] CTRL = 14'h0000;
  localparam logic [13:0] ACC  = 14'h0004;
  localparam logic [13:0] AXOR = 14'h1000;
  localparam logic [13:0] ASET = 14'h2000;
  localparam logic [13:0] ACLR = 14'h3000;

  always #2 clk = ~clk;

  sniffAccReg uut (.*);

  task automatic check(input string req, input logic [13:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    nChecks++;
    if (rdData !== exp) begin
      nFails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic cycle(input bit w, input logic [13:0] a, input logic [31:0] d,
                       input bit s, input logic [31:0] sd, input bit sw);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d;
    sniffValid = s; sniffData = sd; sniffSwap = sw;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; sniffValid = 0; sniffSwap = 0;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    cycle(1, a, d, 0, '0, 0);
  endtask

  task automatic sniff(input logic [31:0] sd, input bit sw);
    cycle(0, ACC, '0, 1, sd, sw);
  endtask

  task automatic testReset;
    check("R1 ctrl", CTRL, 32'h0);
    check("R1 acc", ACC, 32'h0);
  endtask

  task automatic testAliases;
    wr(ACC, 32'h12345678);
    check("R2 plain", ACC, 32'h12345678);
    check("R6 alias1 read", AXOR | ACC, 32'h12345678);
    check("R6 alias2 read", ASET | ACC, 32'h12345678);
    check("R6 alias3 read", ACLR | ACC, 32'h12345678);
    wr(AXOR | ACC, 32'h0000FFFF);
    check("R3 xor", ACC, 32'h1234A987);
    wr(ASET | ACC, 32'hF0000000);
    check("R4 set", ACC, 32'hF234A987);
    wr(ACLR | ACC, 32'h0000FF00);
    check("R5 clear", ACC, 32'hF2340087);
  endtask

  task automatic testCtrl;
    wr(CTRL, 32'hFFFFFFFF);
    check("R11 ctrl mask", CTRL, 32'h000001E1);
    wr(ACLR | CTRL, 32'h000001E0);
    check("R5 ctrl clear", CTRL, 32'h00000001);
  endtask

  task automatic testIgnored;
    sniff(32'h5, 0);
    check("R9 wrong mode", ACC, 32'hF2340087);
    wr(CTRL, 32'h000001E0);
    sniff(32'h5, 0);
    check("R9 disabled", ACC, 32'hF2340087);
  endtask

  task automatic testAdd;
    wr(CTRL, 32'h000001E1);
    wr(ACC, 32'hFFFFFFF0);
    sniff(32'h20, 0);
    check("R7 wrap", ACC, 32'h00000010);
    sniff(32'h10, 0);
    check("R7 double", ACC, 32'h00000020);
    wr(ACC, 32'h0);
    sniff(32'hAB000000, 1);
    check("R8 swap", ACC, 32'h000000AB);
    sniff(32'h00CD0000, 0);
    check("R8 no swap", ACC, 32'h00CD00AB);
  endtask

  task automatic testOrder;
    wr(ACC, 32'hAB);
    cycle(1, AXOR | ACC, 32'hFF, 1, 32'h1, 0);
    check("R10 write then add", ACC, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testAliases();
    testCtrl();
    testIgnored();
    testAdd();
    testOrder();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule